// File: doc/BRIEF.md
# Video Line-Tracking Status Monitor

This block sits beside the receive path of a parallel video capture port and reports on it. It counts valid samples between successive line-start strobes and compares that count with a programmed samples-per-line value. A line that ends early raises a sticky short-line error. In the embedded-sync video mode, a line that runs past the programmed count raises a sticky long-line error. In the general-purpose frame-sync mode the counter stops at the programmed count and waits for the next line start.

The block also tracks the occupancy of the 16-entry receive FIFO from push and pop strobes. It keeps sticky FIFO overflow and underrun errors, and it passes a live field indication through. All four error flags feed one registered interrupt line, and a mask input can suppress each flag's part in it. Code decoding, the DMA side and the transmit modes are done elsewhere. Line-start, field and FIFO strobes arrive already decoded.

Top module: `line_track_monitor`

## Requirements
- R1: Each bit of `errFlags` is sticky. It clears one cycle after a one on the same bit of `clearFlags`. If a new error for that bit arrives in the same cycle as the clear, the flag stays set. Bit map: bit 0 FIFO overflow, bit 1 FIFO underrun, bit 2 long line, bit 3 short line.
- R2: `fifoLevel` counts accepted pushes minus accepted pops, from 0 to `FIFO_DEPTH` (default 16).
  - A push while the level is full and no pop is present is dropped and sets bit 0 one cycle later.
  - A push and a pop together at full leave the level at full with no error.
- R3: A pop while the level is 0 is ignored and sets bit 1 one cycle later.
- R4: In embedded-sync video mode (`mode` = 2), a valid sample that arrives with no line start, after the count has already reached `samplesPerLine`, sets bit 2.
- R5: In general-purpose frame-sync mode (`mode` = 1), reaching `samplesPerLine` never sets bit 2. Further samples are not counted until the next line start.
- R6: In modes 1 and 2, a line start that arrives after fewer than `samplesPerLine` counted samples since the previous line start sets bit 3 one cycle later.
- R7: Line tracking works only in modes 1 and 2.
  - In mode 0 (off) and mode 3 (single-frame receive), bits 2 and 3 are never set and the counter is held idle.
  - The first line start after entering mode 1 or 2 only starts a line and is never checked.
- R8: `fieldOut` is not registered. It equals `embField` in mode 2 and `fs3Field` in every other mode, in the same cycle.
- R9: `errIrq` is registered. It is high in the cycle after any flag bit is set whose `maskFlags` bit is 0, and low otherwise.
- R10: After reset, `errFlags`, `errIrq` and `fifoLevel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 off, 1 frame-sync receive, 2 embedded-sync video receive, 3 single-frame receive |
| samplesPerLine | input | CNT_W | Programmed samples per line |
| lineStart | input | 1 | Line-start strobe (frame sync or decoded start-of-active-video) |
| sampleValid | input | 1 | One valid input sample this cycle |
| embField | input | 1 | Field bit taken from embedded codes |
| fs3Field | input | 1 | Third frame-sync input used as field |
| fifoPush | input | 1 | Receive FIFO write strobe |
| fifoPop | input | 1 | Receive FIFO read strobe |
| clearFlags | input | 4 | Write-one-to-clear pulses per flag |
| maskFlags | input | 4 | Per-flag interrupt suppress (1 = masked) |
| errFlags | output | 4 | Sticky error flags |
| errIrq | output | 1 | Registered error interrupt level |
| fieldOut | output | 1 | Live field indication |
| fifoLevel | output | LVL_W | Receive FIFO occupancy |

## Verification
The line check is tried with every line length from 0 to 8 samples against a programmed count of 5, in each of the two tracking modes and in the single-frame mode. This separates short, exact and long lines, the stall in the frame-sync mode and the silence of the single-frame mode.

The FIFO counter is filled to full and emptied, with one extra push and one extra pop, and with a push and a pop together at full. This shows that the errors depend on simultaneous traffic.

Separate sequences test:
- a clear that coincides with a new error;
- a masked and then unmasked interrupt;
- the field source switching with the mode.

// File: rtl/ltm_pkg.sv
package ltm_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_GP   = 2'd1,
    MODE_VID  = 2'd2,
    MODE_ONCE = 2'd3
  } capMode_e;

  localparam int FLAG_N = 4;

  // Packed so that bit 0 is fifoOver and bit 3 is lineShort.
  typedef struct packed {
    logic lineShort;
    logic lineLong;
    logic fifoUnder;
    logic fifoOver;
  } errStrobe_t;
endpackage

// File: rtl/ltm_ctrl.sv
module ltm_ctrl
  import ltm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  capMode_e         modeSel,
  input  logic [CNT_W-1:0] samplesPerLine,
  input  logic             lineStart,
  input  logic             sampleValid,
  input  logic             embField,
  input  logic             fs3Field,
  input  logic             fifoPush,
  input  logic             fifoPop,
  output errStrobe_t       events,
  output logic             fieldOut,
  output logic [LVL_W-1:0] fifoLevel
);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(FIFO_DEPTH);

  logic [CNT_W-1:0] sampleCnt;
  logic             armed;
  logic             tracking;
  logic             atTarget;
  logic             fifoFull;
  logic             fifoEmpty;
  logic             pushOk;
  logic             popOk;

  assign tracking = (modeSel == MODE_GP) || (modeSel == MODE_VID);
  assign atTarget = sampleCnt >= samplesPerLine;

  // The sample counter restarts at every line start and stalls at the target.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      armed     <= 1'b0;
    end else if (!tracking) begin
      sampleCnt <= '0;
      armed     <= 1'b0;
    end else if (lineStart) begin
      sampleCnt <= sampleValid ? CNT_W'(1) : '0;
      armed     <= 1'b1;
    end else if (sampleValid && !atTarget) begin
      sampleCnt <= sampleCnt + 1'b1;
    end
  end

  assign fifoFull  = (fifoLevel == LVL_FULL);
  assign fifoEmpty = (fifoLevel == '0);
  assign pushOk    = fifoPush && (!fifoFull || fifoPop);
  assign popOk     = fifoPop && !fifoEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) fifoLevel <= '0;
    else if (pushOk && !popOk) fifoLevel <= fifoLevel + 1'b1;
    else if (popOk && !pushOk) fifoLevel <= fifoLevel - 1'b1;
  end

  always_comb begin
    events.lineShort = tracking && armed && lineStart && !atTarget;
    events.lineLong  = (modeSel == MODE_VID) && armed && sampleValid && !lineStart && atTarget;
    events.fifoOver  = fifoPush && fifoFull && !fifoPop;
    events.fifoUnder = fifoPop && fifoEmpty;
  end

  assign fieldOut = (modeSel == MODE_VID) ? embField : fs3Field;
endmodule

// File: rtl/ltm_flags.sv
module ltm_flags
  import ltm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  errStrobe_t        events,
  input  logic [FLAG_N-1:0] clearFlags,
  input  logic [FLAG_N-1:0] maskFlags,
  output logic [FLAG_N-1:0] errFlags,
  output logic              errIrq
);
  logic [FLAG_N-1:0] setVec;
  assign setVec = events;

  // A new error takes priority over a clear in the same cycle.
  for (genvar i = 0; i < FLAG_N; i++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN) errFlags[i] <= 1'b0;
      else errFlags[i] <= (errFlags[i] && !clearFlags[i]) || setVec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errIrq <= 1'b0;
    else errIrq <= |(errFlags & ~maskFlags);
  end
endmodule

// File: rtl/line_track_monitor.sv
module line_track_monitor
  import ltm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] samplesPerLine,
  input  logic             lineStart,
  input  logic             sampleValid,
  input  logic             embField,
  input  logic             fs3Field,
  input  logic             fifoPush,
  input  logic             fifoPop,
  input  logic [3:0]       clearFlags,
  input  logic [3:0]       maskFlags,
  output logic [3:0]       errFlags,
  output logic             errIrq,
  output logic             fieldOut,
  output logic [LVL_W-1:0] fifoLevel
);
  errStrobe_t events;
  capMode_e   modeSel;

  assign modeSel = capMode_e'(mode);

  ltm_ctrl #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .samplesPerLine(samplesPerLine),
    .lineStart(lineStart), .sampleValid(sampleValid), .embField(embField),
    .fs3Field(fs3Field), .fifoPush(fifoPush), .fifoPop(fifoPop),
    .events(events), .fieldOut(fieldOut), .fifoLevel(fifoLevel)
  );

  ltm_flags uFlags (
    .clk(clk), .rstN(rstN), .events(events), .clearFlags(clearFlags),
    .maskFlags(maskFlags), .errFlags(errFlags), .errIrq(errIrq)
  );
endmodule

// File: rtl/ltm_checker.sv
module ltm_checker #(
  parameter int CNT_W = 12,
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] samplesPerLine,
  input logic             fifoPush,
  input logic             fifoPop,
  input logic [3:0]       clearFlags,
  input logic [3:0]       maskFlags,
  input logic [3:0]       errFlags,
  input logic             errIrq,
  input logic [LVL_W-1:0] fifoLevel
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(FIFO_DEPTH);

  a_r1_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((($past(errFlags) & ~$past(clearFlags)) & ~errFlags)) == 4'b0));

  a_r2_over: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPush && !fifoPop && fifoLevel == FULL) |=> (errFlags[0] && fifoLevel == FULL));

  a_r2_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= FULL);

  a_r3_under: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPop && fifoLevel == '0) |=> errFlags[1]);

  a_r5_gp_no_long: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && !errFlags[2]) |=> !errFlags[2]);

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 2'd0 || mode == 2'd3) && errFlags[3:2] == 2'b00) |=> errFlags[3:2] == 2'b00);

  a_r9_irq: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (errIrq == |($past(errFlags) & ~$past(maskFlags))));
endmodule

bind line_track_monitor ltm_checker #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .mode(mode), .samplesPerLine(samplesPerLine),
  .fifoPush(fifoPush), .fifoPop(fifoPop), .clearFlags(clearFlags),
  .maskFlags(maskFlags), .errFlags(errFlags), .errIrq(errIrq), .fifoLevel(fifoLevel)
);

// File: tb/tb_line_track_monitor.sv
`timescale 1ns/1ps
module tb_line_track_monitor;
  localparam int TARGET = 5;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  mode;
  logic [11:0] samplesPerLine;
  logic        lineStart, sampleValid, embField, fs3Field, fifoPush, fifoPop;
  logic [3:0]  clearFlags, maskFlags;
  logic [3:0]  errFlags;
  logic        errIrq, fieldOut;
  logic [4:0]  fifoLevel;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  line_track_monitor dut (
    .clk(clk), .rstN(rstN), .mode(mode), .samplesPerLine(samplesPerLine),
    .lineStart(lineStart), .sampleValid(sampleValid), .embField(embField),
    .fs3Field(fs3Field), .fifoPush(fifoPush), .fifoPop(fifoPop),
    .clearFlags(clearFlags), .maskFlags(maskFlags), .errFlags(errFlags),
    .errIrq(errIrq), .fieldOut(fieldOut), .fifoLevel(fifoLevel)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearAll();
    clearFlags = 4'hF;
    @(negedge clk);
    clearFlags = 4'h0;
  endtask

  // Enter mode m fresh, open a line, feed len samples, then close the line.
  task automatic runLine(logic [1:0] m, int len);
    mode = 2'd0;
    clearAll();
    mode = m;
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    chk("R7 first line start unchecked", {30'd0, errFlags[3:2]}, 32'd0);
    sampleValid = 1'b1;
    repeat (len) @(negedge clk);
    sampleValid = 1'b0;
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; mode = 2'd0; samplesPerLine = 12'(TARGET);
    lineStart = 0; sampleValid = 0; embField = 0; fs3Field = 0;
    fifoPush = 0; fifoPop = 0; clearFlags = 0; maskFlags = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 flags", {28'd0, errFlags}, 32'd0);
    chk("R10 irq", {31'd0, errIrq}, 32'd0);
    chk("R10 level", {27'd0, fifoLevel}, 32'd0);

    // Line length sweep in modes 1, 2 and 3.
    for (int mi = 1; mi <= 3; mi++) begin
      for (int len = 0; len <= 8; len++) begin
        logic expShort, expLong;
        runLine(2'(mi), len);
        expShort = (mi != 3) && (len < TARGET);
        expLong  = (mi == 2) && (len > TARGET);
        chk(mi == 3 ? "R7 short" : "R6 short", {31'd0, errFlags[3]}, {31'd0, expShort});
        chk(mi == 2 ? "R4 long" : (mi == 1 ? "R5 long" : "R7 long"),
            {31'd0, errFlags[2]}, {31'd0, expLong});
      end
    end

    // Mode 0 never tracks.
    runLine(2'd0, 2);
    chk("R7 off mode", {30'd0, errFlags[3:2]}, 32'd0);

    // Interrupt masking: short line in mode 1.
    maskFlags = 4'b1000;
    runLine(2'd1, 1);
    chk("R9 flag set while masked", {31'd0, errFlags[3]}, 32'd1);
    @(negedge clk);
    chk("R9 masked irq", {31'd0, errIrq}, 32'd0);
    maskFlags = 4'b0000;
    @(negedge clk);
    chk("R9 unmasked irq", {31'd0, errIrq}, 32'd1);

    // A clear in the same cycle as a new short line: the set wins.
    lineStart = 1'b1; clearFlags = 4'b1000;
    @(negedge clk);
    lineStart = 1'b0; clearFlags = 4'b0000;
    chk("R1 set wins over clear", {31'd0, errFlags[3]}, 32'd1);
    clearFlags = 4'b1000;
    @(negedge clk);
    clearFlags = 4'b0000;
    chk("R1 clear", {31'd0, errFlags[3]}, 32'd0);
    @(negedge clk);
    chk("R9 irq drops", {31'd0, errIrq}, 32'd0);
    chk("R1 flag stays clear", {31'd0, errFlags[3]}, 32'd0);

    // FIFO fill, overflow, simultaneous push and pop at full, drain, underrun.
    mode = 2'd0;
    clearAll();
    fifoPush = 1'b1;
    repeat (16) @(negedge clk);
    fifoPush = 1'b0;
    chk("R2 full level", {27'd0, fifoLevel}, 32'd16);
    chk("R2 no overflow at fill", {31'd0, errFlags[0]}, 32'd0);
    fifoPush = 1'b1;
    @(negedge clk);
    fifoPush = 1'b0;
    chk("R2 overflow", {31'd0, errFlags[0]}, 32'd1);
    chk("R2 level held", {27'd0, fifoLevel}, 32'd16);
    @(negedge clk);
    chk("R1 overflow sticky", {31'd0, errFlags[0]}, 32'd1);
    clearAll();
    fifoPush = 1'b1; fifoPop = 1'b1;
    @(negedge clk);
    fifoPush = 1'b0; fifoPop = 1'b0;
    chk("R2 push+pop at full", {31'd0, errFlags[0]}, 32'd0);
    chk("R2 push+pop level", {27'd0, fifoLevel}, 32'd16);
    fifoPop = 1'b1;
    repeat (16) @(negedge clk);
    fifoPop = 1'b0;
    chk("R3 drained", {27'd0, fifoLevel}, 32'd0);
    chk("R3 no underrun at drain", {31'd0, errFlags[1]}, 32'd0);
    fifoPop = 1'b1;
    @(negedge clk);
    fifoPop = 1'b0;
    chk("R3 underrun", {31'd0, errFlags[1]}, 32'd1);
    chk("R3 level stays 0", {27'd0, fifoLevel}, 32'd0);

    // Live field copy.
    mode = 2'd2; embField = 1'b1; fs3Field = 1'b0;
    #1 chk("R8 video field", {31'd0, fieldOut}, 32'd1);
    embField = 1'b0;
    #1 chk("R8 video field low", {31'd0, fieldOut}, 32'd0);
    mode = 2'd1; fs3Field = 1'b1;
    #1 chk("R8 frame-sync field", {31'd0, fieldOut}, 32'd1);
    mode = 2'd3; fs3Field = 1'b0; embField = 1'b1;
    #1 chk("R8 single-frame field", {31'd0, fieldOut}, 32'd0);
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule